// File: doc/BRIEF.md
# Base Address Register Configuration File

This block holds the base address registers of one endpoint's configuration space, together with a small amount of general configuration storage and a fixed capability for resizable windows. Software sizes each window by writing all ones to its register and reading back an alignment mask, then assigns a base address with an ordinary write. The first window is 64 bits wide and prefetchable, so its base is split between its own register and the dword that follows it. Two register positions are unused and stay at zero.

Once bases are assigned, the block decodes incoming memory addresses. It reports which window an address falls in and the offset from that window's base, or it flags the address as unmapped. Configuration accesses are dword wide and carry byte enables. Reads are combinational on the dword index, and writes take effect at the clock edge.

Top module: `bar_cfg_regs`

## Requirements
- R1: After reset the dword at byte offset 0x10 reads 0x0000000C, and the dwords at 0x14 through 0x24 read 0x00000000.
- R2: Full (byte enables 4'hF) writes to the unused registers at 0x1C and 0x20 are ignored, and those registers keep reading 0.
- R3: A full write of 0xFFFFFFFF to a sized register (0x10, 0x18, 0x24) makes it read (~(size-1)) & 0xFFFFFFF0 | type, where type is 0xC for 0x10 and 0 otherwise.
- R4: Any other full write to a sized register is read back unchanged and assigns that window's base as the value with bits 3:0 cleared.
- R5: A full write to 0x14 is read back unchanged. A value other than all ones sets bits 63:32 of the 0x10 window's base, whose bits 31:0 come from the 0x10 register with bits 3:0 cleared.
- R6: A write whose byte enables are not all set merges only the enabled bytes (enable bit i covers data bits 8i+7:8i) into the addressed dword, and it neither probes nor changes any assigned base.
- R7: Dwords below byte offset 4*GEN_DWORDS, outside 0x10 to 0x27, are read/write storage that resets to 0. Unimplemented dwords read 0.
- R8: The dword at 0x100 reads 0x00010015 and the dword at 0x104 reads 0x00003FF0 (size bits 4 to 13). Both ignore writes.
- R9: A requested memory address that lies in no assigned window raises miss_o with hit_o low. Reset clears all base assignments.
- R10: A requested address in an assigned window raises hit_o. hit_idx_o gives the register slot (0 for 0x10, 2 for 0x18, 5 for 0x24) and hit_off_o gives the address minus the base. When windows overlap, the lowest slot wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dw_i | input | 10 | Dword index (byte offset / 4) of the access |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the indexed dword |
| mem_req_i | input | 1 | Memory address decode request |
| mem_addr_i | input | 64 | Memory address to decode |
| hit_o | output | 1 | Address falls in an assigned window |
| hit_idx_o | output | 3 | Slot of the window that was hit |
| hit_off_o | output | 64 | Offset from the hit window's base |
| miss_o | output | 1 | Requested address is unmapped |

## Verification
The configuration path is exercised with several write patterns: all-ones probes, ordinary values, partial byte-enable writes, and writes to unused or read-only positions. Each one is followed by a readback, which separates mask generation from storing the raw value, from byte merging and from ignoring the write. The decode path is driven with addresses before assignment, inside and outside assigned windows, inside two overlapping windows, and inside the 64-bit window both before and after its upper half is set. These cases separate the range compare, the slot priority and the assembly of the upper base. A mid-run reset then shows that both register contents and assignments are cleared.

// File: rtl/bar_cfg_pkg.sv
package bar_cfg_pkg;
  localparam int NUM_SLOTS   = 6;        // dwords 0x10..0x24
  localparam int SLOT_FIRST  = 4;        // dword index of 0x10
  localparam int SLOT_W      = 3;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] TYPE_PF64 = 32'h0000_000C;
  localparam logic [9:0]  CAP_HDR_DW  = 10'h040;
  localparam logic [9:0]  CAP_SIZE_DW = 10'h041;
  localparam logic [31:0] CAP_HDR   = 32'h0001_0015;
  localparam logic [31:0] CAP_SIZES = 32'h0000_3FF0;

  typedef logic [63:0] addr_t;

  function automatic logic [31:0] be_merge(logic [31:0] old_v, logic [31:0] new_v,
                                           logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/bar_cfg_store.sv
module bar_cfg_store #(
  parameter int DWORDS = 64,
  localparam int AW = $clog2(DWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [DWORDS-1:0][31:0] mem_q;

  for (genvar d = 0; d < DWORDS; d++) begin : g_dw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[d] <= '0;
      else if (we_i && idx_i == AW'(d)) mem_q[d] <= bar_cfg_pkg::be_merge(mem_q[d], wdata_i, be_i);
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/bar_cfg_decode.sv
module bar_cfg_decode #(
  parameter int N = 6,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][63:0] base_i,
  input  logic [N-1:0][63:0] size_i,
  input  logic [N-1:0]       valid_i,
  input  logic               req_i,
  input  logic [63:0]        addr_i,
  output logic               hit_o,
  output logic [IW-1:0]      idx_o,
  output logic [63:0]        off_o,
  output logic               miss_o
);
  logic [N-1:0][63:0] diff;
  logic [N-1:0]       match;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign diff[k]  = addr_i - base_i[k];
    // unsigned wrap makes addr < base land far above size
    assign match[k] = valid_i[k] && (diff[k] < size_i[k]);
  end

  always_comb begin
    idx_o = '0;
    off_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) begin
        idx_o = IW'(k);
        off_o = diff[k];
      end
    end
    hit_o  = req_i && (match != '0);
    miss_o = req_i && (match == '0);
    if (!req_i) off_o = '0;
  end
endmodule

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
  import bar_cfg_pkg::*;
#(
  parameter logic [63:0] BAR0_SIZE  = 64'h1000_0000,
  parameter logic [31:0] BAR2_SIZE  = 32'h0000_2000,
  parameter logic [31:0] BAR5_SIZE  = 32'h0008_0000,
  parameter int          GEN_DWORDS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [9:0]  cfg_dw_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        mem_req_i,
  input  logic [63:0] mem_addr_i,
  output logic        hit_o,
  output logic [2:0]  hit_idx_o,
  output logic [63:0] hit_off_o,
  output logic        miss_o
);
  localparam int GAW = $clog2(GEN_DWORDS);
  localparam logic [NUM_SLOTS-1:0][63:0] SLOT_SIZE =
    {64'(BAR5_SIZE), 64'd0, 64'd0, 64'(BAR2_SIZE), 64'd0, BAR0_SIZE};
  localparam logic [NUM_SLOTS-1:0][31:0] SLOT_TYPE =
    {32'd0, 32'd0, 32'd0, 32'd0, 32'd0, TYPE_PF64};

  logic [NUM_SLOTS-1:0][31:0] bar_q;
  logic [NUM_SLOTS-1:0][63:0] base_q;
  logic [NUM_SLOTS-1:0]       asg_q;

  logic              in_bar, full_wr, probe;
  logic [SLOT_W-1:0] sel;
  logic [31:0]       store_rdata;

  assign in_bar  = cfg_dw_i >= 10'(SLOT_FIRST) && cfg_dw_i < 10'(SLOT_FIRST + NUM_SLOTS);
  assign sel     = SLOT_W'(cfg_dw_i - 10'(SLOT_FIRST));
  assign full_wr = cfg_we_i && in_bar && cfg_be_i == 4'hF;
  assign probe   = cfg_wdata_i == ALL_ONES;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam bit          SIZED = (k != 1) && (SLOT_SIZE[k] != 64'd0);
    localparam logic [31:0] RST_V = SIZED ? SLOT_TYPE[k] : 32'd0;
    localparam logic [31:0] MASK  =
      ((~(SLOT_SIZE[k][31:0] - 32'd1)) & 32'hFFFF_FFF0) | SLOT_TYPE[k];
    logic wr_k;
    assign wr_k = cfg_we_i && in_bar && sel == SLOT_W'(k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bar_q[k] <= RST_V;
      else if (wr_k) begin
        if (cfg_be_i != 4'hF)  bar_q[k] <= be_merge(bar_q[k], cfg_wdata_i, cfg_be_i);
        else if (k == 1)       bar_q[k] <= cfg_wdata_i;   // upper half of 64-bit window
        else if (!SIZED)       bar_q[k] <= bar_q[k];      // unused slot
        else if (probe)        bar_q[k] <= MASK;
        else                   bar_q[k] <= cfg_wdata_i;
      end
    end

    if (k == 0 && SIZED) begin : g_base64
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q[k] <= '0;
          asg_q[k]  <= 1'b0;
        end else if (full_wr && !probe && sel == SLOT_W'(0)) begin
          base_q[k] <= {bar_q[1], cfg_wdata_i & 32'hFFFF_FFF0};
          asg_q[k]  <= 1'b1;
        end else if (full_wr && !probe && sel == SLOT_W'(1)) begin
          base_q[k] <= {cfg_wdata_i, bar_q[0] & 32'hFFFF_FFF0};
          asg_q[k]  <= 1'b1;
        end
      end
    end else if (SIZED) begin : g_base32
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q[k] <= '0;
          asg_q[k]  <= 1'b0;
        end else if (full_wr && !probe && sel == SLOT_W'(k)) begin
          base_q[k] <= {32'd0, cfg_wdata_i & 32'hFFFF_FFF0};
          asg_q[k]  <= 1'b1;
        end
      end
    end else begin : g_nobase
      assign base_q[k] = '0;
      assign asg_q[k]  = 1'b0;
    end
  end

  bar_cfg_store #(.DWORDS(GEN_DWORDS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && !in_bar && cfg_dw_i < 10'(GEN_DWORDS)),
    .idx_i   (cfg_dw_i[GAW-1:0]),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (store_rdata)
  );

  always_comb begin
    if (in_bar)                          cfg_rdata_o = bar_q[sel];
    else if (cfg_dw_i == CAP_HDR_DW)     cfg_rdata_o = CAP_HDR;
    else if (cfg_dw_i == CAP_SIZE_DW)    cfg_rdata_o = CAP_SIZES;
    else if (cfg_dw_i < 10'(GEN_DWORDS)) cfg_rdata_o = store_rdata;
    else                                 cfg_rdata_o = '0;
  end

  bar_cfg_decode #(.N(NUM_SLOTS)) u_dec (
    .base_i  (base_q),
    .size_i  (SLOT_SIZE),
    .valid_i (asg_q),
    .req_i   (mem_req_i),
    .addr_i  (mem_addr_i),
    .hit_o   (hit_o),
    .idx_o   (hit_idx_o),
    .off_o   (hit_off_o),
    .miss_o  (miss_o)
  );
endmodule

// File: rtl/bar_cfg_regs_chk.sv
module bar_cfg_regs_chk #(
  parameter logic [31:0] BAR2_SIZE = 32'h0000_2000,
  parameter logic [31:0] BAR5_SIZE = 32'h0008_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [9:0]       cfg_dw_i,
  input logic [3:0]       cfg_be_i,
  input logic [31:0]      cfg_wdata_i,
  input logic             mem_req_i,
  input logic             hit_o,
  input logic [2:0]       hit_idx_o,
  input logic [63:0]      hit_off_o,
  input logic             miss_o,
  input logic [5:0][31:0] bar_q,
  input logic [5:0]       asg_q
);
  localparam logic [31:0] MASK2 = (~(BAR2_SIZE - 32'd1)) & 32'hFFFF_FFF0;

  AST_PROBE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_dw_i == 10'h006 && cfg_be_i == 4'hF && cfg_wdata_i == 32'hFFFF_FFFF
    |=> bar_q[2] == MASK2); // R3

  AST_UNUSED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_dw_i == 10'h007 || cfg_dw_i == 10'h008) && cfg_be_i == 4'hF
    |=> $stable(bar_q[3]) && $stable(bar_q[4])); // R2

  AST_STORE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_dw_i == 10'h009 && cfg_be_i == 4'hF && cfg_wdata_i != 32'hFFFF_FFFF
    |=> bar_q[5] == $past(cfg_wdata_i)); // R4

  AST_MISS_UNASSIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && asg_q == 6'd0 |-> miss_o && !hit_o); // R9

  AST_HIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o || miss_o |-> mem_req_i && !(hit_o && miss_o)); // R10

  AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && hit_idx_o == 3'd5 |-> hit_off_o < 64'(BAR5_SIZE)); // R10
endmodule

bind bar_cfg_regs bar_cfg_regs_chk #(.BAR2_SIZE(BAR2_SIZE), .BAR5_SIZE(BAR5_SIZE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_dw_i    (cfg_dw_i),
  .cfg_be_i    (cfg_be_i),
  .cfg_wdata_i (cfg_wdata_i),
  .mem_req_i   (mem_req_i),
  .hit_o       (hit_o),
  .hit_idx_o   (hit_idx_o),
  .hit_off_o   (hit_off_o),
  .miss_o      (miss_o),
  .bar_q       (bar_q),
  .asg_q       (asg_q)
);

// File: tb/bar_cfg_regs_bench.sv
module bar_cfg_regs_bench;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_MEM = 2'd2;
  localparam logic [63:0] MISS = 64'h4000_0000_0000_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] a;     // byte offset
    logic [3:0]  be;
    logic [63:0] d;     // write data or memory address
    logic [63:0] exp;   // read data, or {hit,miss,..,idx[34:32],off[31:0]}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  12'h010, 4'h0, 64'h0, 64'h0000_000C, 4'd1},             // R1
    '{OP_RD,  12'h018, 4'h0, 64'h0, 64'h0, 4'd1},                     // R1
    '{OP_MEM, 12'h000, 4'h0, 64'h0, MISS, 4'd9},                      // R9
    '{OP_WR,  12'h010, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd3},
    '{OP_RD,  12'h010, 4'h0, 64'h0, 64'hF000_000C, 4'd3},             // R3
    '{OP_WR,  12'h018, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd3},
    '{OP_RD,  12'h018, 4'h0, 64'h0, 64'hFFFF_E000, 4'd3},             // R3
    '{OP_WR,  12'h024, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd3},
    '{OP_RD,  12'h024, 4'h0, 64'h0, 64'hFFF8_0000, 4'd3},             // R3
    '{OP_WR,  12'h01C, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd2},
    '{OP_RD,  12'h01C, 4'h0, 64'h0, 64'h0, 4'd2},                     // R2
    '{OP_WR,  12'h020, 4'hF, 64'h1234_5678, 64'h0, 4'd2},
    '{OP_RD,  12'h020, 4'h0, 64'h0, 64'h0, 4'd2},                     // R2
    '{OP_WR,  12'h018, 4'hF, 64'h0000_4005, 64'h0, 4'd4},
    '{OP_RD,  12'h018, 4'h0, 64'h0, 64'h0000_4005, 4'd4},             // R4
    '{OP_MEM, 12'h000, 4'h0, 64'h4010, 64'h8000_0002_0000_0010, 4'd10}, // R10
    '{OP_MEM, 12'h000, 4'h0, 64'h6000, MISS, 4'd9},                   // R9
    '{OP_WR,  12'h024, 4'hF, 64'h0, 64'h0, 4'd10},
    '{OP_MEM, 12'h000, 4'h0, 64'h4010, 64'h8000_0002_0000_0010, 4'd10}, // R10 priority
    '{OP_MEM, 12'h000, 4'h0, 64'h6000, 64'h8000_0005_0000_6000, 4'd10}, // R10
    '{OP_WR,  12'h014, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd5},
    '{OP_RD,  12'h014, 4'h0, 64'h0, 64'hFFFF_FFFF, 4'd5},             // R5
    '{OP_MEM, 12'h000, 4'h0, 64'h1_2000_0000, MISS, 4'd5},            // R5
    '{OP_WR,  12'h014, 4'hF, 64'h1, 64'h0, 4'd5},
    '{OP_WR,  12'h010, 4'hF, 64'h2000_0008, 64'h0, 4'd4},
    '{OP_RD,  12'h010, 4'h0, 64'h0, 64'h2000_0008, 4'd4},             // R4
    '{OP_MEM, 12'h000, 4'h0, 64'h1_2000_0100, 64'h8000_0000_0000_0100, 4'd5}, // R5
    '{OP_WR,  12'h024, 4'h1, 64'hAB, 64'h0, 4'd6},
    '{OP_RD,  12'h024, 4'h0, 64'h0, 64'hAB, 4'd6},                    // R6
    '{OP_MEM, 12'h000, 4'h0, 64'h6000, 64'h8000_0005_0000_6000, 4'd6}, // R6
    '{OP_WR,  12'h040, 4'hF, 64'hDEAD_BEEF, 64'h0, 4'd7},
    '{OP_RD,  12'h040, 4'h0, 64'h0, 64'hDEAD_BEEF, 4'd7},             // R7
    '{OP_WR,  12'h040, 4'h4, 64'h0055_0000, 64'h0, 4'd6},
    '{OP_RD,  12'h040, 4'h0, 64'h0, 64'hDE55_BEEF, 4'd6},             // R6
    '{OP_RD,  12'h100, 4'h0, 64'h0, 64'h0001_0015, 4'd8},             // R8
    '{OP_WR,  12'h100, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd8},
    '{OP_RD,  12'h100, 4'h0, 64'h0, 64'h0001_0015, 4'd8},             // R8
    '{OP_RD,  12'h104, 4'h0, 64'h0, 64'h0000_3FF0, 4'd8},             // R8
    '{OP_RD,  12'h200, 4'h0, 64'h0, 64'h0, 4'd7},                     // R7
    '{OP_WR,  12'h018, 4'h3, 64'h0000_FFFF, 64'h0, 4'd6},
    '{OP_RD,  12'h018, 4'h0, 64'h0, 64'h0000_FFFF, 4'd6},             // R6
    '{OP_MEM, 12'h000, 4'h0, 64'h4010, 64'h8000_0002_0000_0010, 4'd6}  // R6 base kept
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req = 1'b0;
  logic [63:0] mem_addr = '0;
  logic        hit, miss;
  logic [2:0]  hit_idx;
  logic [63:0] hit_off;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bar_cfg_regs u_bar_cfg_regs (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_dw_i(cfg_dw), .cfg_be_i(cfg_be),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .mem_req_i(mem_req),
    .mem_addr_i(mem_addr), .hit_o(hit), .hit_idx_o(hit_idx), .hit_off_o(hit_off),
    .miss_o(miss)
  );

  task automatic check(int req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    cfg_dw = v.a[11:2];
    cfg_be = v.be;
    cfg_wdata = v.d[31:0];
    mem_addr = v.d;
    mem_req = (v.op == OP_MEM);
    if (v.op == OP_WR) begin
      cfg_we = 1'b1;
      @(posedge clk);
      #1 cfg_we = 1'b0;
    end else begin
      #1;
      if (v.op == OP_RD) check(int'(v.req), {32'd0, cfg_rdata}, v.exp);
      else check(int'(v.req), {hit, miss, 27'd0, hit_idx, hit_off[31:0]}, v.exp);
      mem_req = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // mid-run reset clears registers and assignments: R1, R7, R9
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    apply('{OP_RD,  12'h010, 4'h0, 64'h0, 64'h0000_000C, 4'd1});   // R1
    apply('{OP_RD,  12'h024, 4'h0, 64'h0, 64'h0, 4'd1});           // R1
    apply('{OP_RD,  12'h040, 4'h0, 64'h0, 64'h0, 4'd7});           // R7
    apply('{OP_MEM, 12'h000, 4'h0, 64'h4010, MISS, 4'd9});         // R9
    // unused slot ignores a full write even right after reset: R2
    apply('{OP_WR,  12'h020, 4'hF, 64'hFFFF_FFFF, 64'h0, 4'd2});
    apply('{OP_RD,  12'h020, 4'h0, 64'h0, 64'h0, 4'd2});           // R2
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R0 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule